// File: doc/BRIEF.md
# Reorder Buffer with Deferred Faults

This block keeps micro-operations in program order while they execute out of order. A front end claims a slot through the allocate port and receives a tag. Execution units later report each tag as complete, in any order. A completion carries a result value, a fault flag and a branch-mispredict flag. The oldest entry leaves through the retire outputs once it is complete, at most one entry per cycle.

A fault does not stall anything when it is reported. It only marks its entry. The exception is raised when that entry becomes the oldest one. All entries are then dropped, so the state the handler sees is precise. A mispredicted branch behaves differently: it trims only the entries younger than itself. The branch and the older in-flight work keep running. A store's release to the store buffer is given only when the store retires.

The buffer holds 16 entries. Tags are slot indices, and they wrap modulo 16.

Top module: `rob_core`

## Requirements
- R1: `alloc_tag` shows the tag the next allocation receives, which is the previous allocated tag plus one modulo 16. `alloc_ready` is low while 16 entries are live, and an allocation attempt in that state is ignored.
- R2: Entries may complete in any order. Retirement follows program order only. `ret_valid` is high exactly when the oldest live entry has completed without a fault, and one entry retires per such cycle, with `ret_tag` and `ret_result` showing that entry.
- R3: A fault reported at completion does not raise an exception while older entries are still live. In the meantime, allocation and the completion of other entries go on as usual.
- R4: When several entries fault, the exception names the oldest of them, even if a younger one completed first.
- R5: `exc_valid` is high exactly when the oldest live entry has completed with a fault. `exc_tag` shows that entry's tag, and `ret_valid` stays low in that cycle. After the edge, the buffer is empty, and the next allocated tag is the faulting tag plus one. `alloc_ready` is low during the exception cycle.
- R6: A live completion with `cmp_mispredict` high discards every entry younger than that tag. The branch and the older entries remain and may still complete and retire. The next allocated tag is the branch tag plus one. An allocation in the same cycle is discarded.
- R7: `store_release` is high only in a cycle where an entry allocated with `alloc_is_store` high retires normally. A faulting store never releases.
- R8: A completion whose tag is not a live entry is ignored, including tags discarded by a mispredict or by an exception flush.
- R9: After synchronous reset, the buffer is empty: `alloc_ready` is 1, `alloc_tag` is 0, and `ret_valid`, `exc_valid` and `store_release` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Request to allocate one entry |
| alloc_is_store | input | 1 | The allocated micro-op is a store |
| alloc_ready | output | 1 | Allocation is accepted this cycle |
| alloc_tag | output | 4 | Tag given to the entry allocated this cycle |
| cmp_valid | input | 1 | A completion is reported |
| cmp_tag | input | 4 | Tag of the completed entry |
| cmp_result | input | 32 | Result value of the completed entry |
| cmp_fault | input | 1 | The completed entry faulted |
| cmp_mispredict | input | 1 | The completed entry is a mispredicted branch |
| ret_valid | output | 1 | The oldest entry retires normally this cycle |
| ret_tag | output | 4 | Tag of the oldest entry |
| ret_result | output | 32 | Result of the retiring entry |
| store_release | output | 1 | The retiring entry is a store and may drain |
| exc_valid | output | 1 | The oldest entry faulted; exception and flush |
| exc_tag | output | 4 | Tag of the faulting entry |

## Verification
The bound checker watches invariants on every cycle:
- the occupancy never exceeds 16, and allocation is refused when the buffer is full;
- the head advances only on a retirement or an exception, and retirement and exception are never signalled together;
- an exception empties the buffer and moves the next tag past the faulting one;
- a mispredict rewinds the next tag to just after the branch;
- an out-of-range completion leaves the occupancy untouched;
- a store release only accompanies a retirement.

Whether the right fault wins, whether results follow their tags, and whether discarded entries stay gone can only be shown by the bench scenarios. These run under a queue-based reference model: reverse-order completion, faults in nested order, a mispredict combined with an allocation in the same cycle, and long random mixes.

// File: rtl/rob_pkg.sv
package rob_pkg;

    parameter int unsigned ROB_DEPTH = 16;
    parameter int unsigned DATA_W    = 32;

    localparam int unsigned TAG_W = $clog2(ROB_DEPTH);

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [TAG_W:0]    cnt_t;
    typedef logic [DATA_W-1:0] data_t;

    localparam tag_t TAG_ONE  = tag_t'(1);
    localparam cnt_t CNT_FULL = cnt_t'(ROB_DEPTH);

    // State kept for each slot of the ring.
    typedef struct packed {
        logic  done;
        logic  fault;
        logic  is_store;
        data_t result;
    } slot_t;

    // Distance of a tag from the oldest entry, in program order.
    function automatic tag_t tag_age(tag_t tag, tag_t head);
        return tag - head;
    endfunction

endpackage

// File: rtl/rob_decide.sv
module rob_decide
    import rob_pkg::*;
(
    input  tag_t  head_q,
    input  cnt_t  count_q,
    input  slot_t head_slot,
    input  logic  alloc_valid,
    input  logic  cmp_valid,
    input  tag_t  cmp_tag,
    input  logic  cmp_mispredict,
    output logic  retire_ok,
    output logic  exc_now,
    output logic  alloc_ok,
    output logic  alloc_fire,
    output logic  live_cmp,
    output logic  mp_fire,
    output tag_t  cmp_age
);

    logic occupied;

    always_comb begin
        occupied   = (count_q != '0);
        retire_ok  = occupied && head_slot.done && !head_slot.fault;
        exc_now    = occupied && head_slot.done &&  head_slot.fault;
        alloc_ok   = (count_q != CNT_FULL) && !exc_now;
        alloc_fire = alloc_valid && alloc_ok;
        cmp_age    = tag_age(cmp_tag, head_q);
        live_cmp   = cmp_valid && !exc_now && ({1'b0, cmp_age} < count_q);
        mp_fire    = live_cmp && cmp_mispredict;
    end

endmodule

// File: rtl/rob_ptrs.sv
module rob_ptrs
    import rob_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic retire_ok,
    input  logic exc_now,
    input  logic alloc_fire,
    input  logic mp_fire,
    input  tag_t mp_tag,
    input  tag_t mp_age,
    output tag_t head_q,
    output tag_t tail_q,
    output cnt_t count_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else if (exc_now) begin
            // Precise flush: everything goes, numbering resumes after the fault.
            head_q  <= head_q + TAG_ONE;
            tail_q  <= head_q + TAG_ONE;
            count_q <= '0;
        end else begin
            head_q <= retire_ok ? head_q + TAG_ONE : head_q;
            if (mp_fire) begin
                // Keep the branch and everything older; drop the rest.
                tail_q  <= mp_tag + TAG_ONE;
                count_q <= cnt_t'(mp_age) + cnt_t'(1) - cnt_t'(retire_ok);
            end else begin
                tail_q  <= alloc_fire ? tail_q + TAG_ONE : tail_q;
                count_q <= count_q + cnt_t'(alloc_fire) - cnt_t'(retire_ok);
            end
        end
    end

endmodule

// File: rtl/rob_slots.sv
module rob_slots
    import rob_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  alloc_fire,
    input  tag_t  alloc_idx,
    input  logic  alloc_store,
    input  logic  cmp_live,
    input  tag_t  cmp_idx,
    input  data_t cmp_result,
    input  logic  cmp_fault,
    input  tag_t  rd_idx,
    output slot_t rd_slot
);

    slot_t view [ROB_DEPTH];

    for (genvar g = 0; g < ROB_DEPTH; g++) begin : g_slot
        slot_t s_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                s_q <= '0;
            end else if (alloc_fire && alloc_idx == tag_t'(g)) begin
                s_q.done     <= 1'b0;
                s_q.fault    <= 1'b0;
                s_q.is_store <= alloc_store;
            end else if (cmp_live && cmp_idx == tag_t'(g)) begin
                s_q.done   <= 1'b1;
                s_q.fault  <= cmp_fault;
                s_q.result <= cmp_result;
            end
        end

        assign view[g] = s_q;
    end

    assign rd_slot = view[rd_idx];

endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic              alloc_is_store,
    output logic              alloc_ready,
    output logic [TAG_W-1:0]  alloc_tag,
    input  logic              cmp_valid,
    input  logic [TAG_W-1:0]  cmp_tag,
    input  logic [DATA_W-1:0] cmp_result,
    input  logic              cmp_fault,
    input  logic              cmp_mispredict,
    output logic              ret_valid,
    output logic [TAG_W-1:0]  ret_tag,
    output logic [DATA_W-1:0] ret_result,
    output logic              store_release,
    output logic              exc_valid,
    output logic [TAG_W-1:0]  exc_tag
);

    tag_t  head_q;
    tag_t  tail_q;
    cnt_t  count_q;
    slot_t head_slot;
    logic  retire_ok;
    logic  exc_now;
    logic  alloc_ok;
    logic  alloc_fire;
    logic  live_cmp;
    logic  mp_fire;
    tag_t  cmp_age;

    rob_decide u_decide (
        .head_q         (head_q),
        .count_q        (count_q),
        .head_slot      (head_slot),
        .alloc_valid    (alloc_valid),
        .cmp_valid      (cmp_valid),
        .cmp_tag        (cmp_tag),
        .cmp_mispredict (cmp_mispredict),
        .retire_ok      (retire_ok),
        .exc_now        (exc_now),
        .alloc_ok       (alloc_ok),
        .alloc_fire     (alloc_fire),
        .live_cmp       (live_cmp),
        .mp_fire        (mp_fire),
        .cmp_age        (cmp_age)
    );

    rob_ptrs u_ptrs (
        .clk        (clk),
        .rst        (rst),
        .retire_ok  (retire_ok),
        .exc_now    (exc_now),
        .alloc_fire (alloc_fire),
        .mp_fire    (mp_fire),
        .mp_tag     (cmp_tag),
        .mp_age     (cmp_age),
        .head_q     (head_q),
        .tail_q     (tail_q),
        .count_q    (count_q)
    );

    rob_slots u_slots (
        .clk         (clk),
        .rst         (rst),
        .alloc_fire  (alloc_fire),
        .alloc_idx   (tail_q),
        .alloc_store (alloc_is_store),
        .cmp_live    (live_cmp),
        .cmp_idx     (cmp_tag),
        .cmp_result  (cmp_result),
        .cmp_fault   (cmp_fault),
        .rd_idx      (head_q),
        .rd_slot     (head_slot)
    );

    assign alloc_ready   = alloc_ok;
    assign alloc_tag     = tail_q;
    assign ret_valid     = retire_ok;
    assign ret_tag       = head_q;
    assign ret_result    = head_slot.result;
    assign store_release = retire_ok && head_slot.is_store;
    assign exc_valid     = exc_now;
    assign exc_tag       = head_q;

endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk
    import rob_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic alloc_valid,
    input logic alloc_ready,
    input tag_t alloc_tag,
    input logic cmp_valid,
    input tag_t cmp_tag,
    input logic cmp_mispredict,
    input logic ret_valid,
    input tag_t ret_tag,
    input logic store_release,
    input logic exc_valid,
    input tag_t exc_tag,
    input cnt_t count_q
);

    tag_t chk_age;
    logic chk_in_range;

    assign chk_age      = cmp_tag - ret_tag;
    assign chk_in_range = ({1'b0, chk_age} < count_q);

    // R1
    p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_FULL);

    // R1
    p_full_refuse_r1: assert property (@(posedge clk) disable iff (rst)
        (count_q == CNT_FULL) |-> !alloc_ready);

    // R2
    p_head_step_r2: assert property (@(posedge clk) disable iff (rst)
        ret_valid |=> (ret_tag == tag_t'($past(ret_tag) + TAG_ONE)));

    // R2
    p_head_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!ret_valid && !exc_valid) |=> (ret_tag == $past(ret_tag)));

    // R2
    p_empty_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (count_q == '0) |-> (!ret_valid && !exc_valid));

    // R5
    p_single_event_r5: assert property (@(posedge clk) disable iff (rst)
        !(ret_valid && exc_valid));

    // R5
    p_exc_flush_r5: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> (count_q == '0) && (alloc_tag == tag_t'($past(exc_tag) + TAG_ONE)));

    // R5
    p_exc_blocks_alloc_r5: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> !alloc_ready);

    // R6
    p_mp_rewind_r6: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_mispredict && chk_in_range && !exc_valid)
        |=> (alloc_tag == tag_t'($past(cmp_tag) + TAG_ONE)));

    // R7
    p_release_retire_r7: assert property (@(posedge clk) disable iff (rst)
        store_release |-> ret_valid);

    // R8
    p_ignore_stray_r8: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && !chk_in_range && !exc_valid)
        |=> (count_q == $past(count_q) + cnt_t'($past(alloc_valid && alloc_ready))
                        - cnt_t'($past(ret_valid))));

endmodule

bind rob_core rob_core_chk u_rob_core_chk (
    .clk            (clk),
    .rst            (rst),
    .alloc_valid    (alloc_valid),
    .alloc_ready    (alloc_ready),
    .alloc_tag      (alloc_tag),
    .cmp_valid      (cmp_valid),
    .cmp_tag        (cmp_tag),
    .cmp_mispredict (cmp_mispredict),
    .ret_valid      (ret_valid),
    .ret_tag        (ret_tag),
    .store_release  (store_release),
    .exc_valid      (exc_valid),
    .exc_tag        (exc_tag),
    .count_q        (count_q)
);

// File: tb/test_rob_core.sv
`timescale 1ns/1ps
module test_rob_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        alloc_valid = 1'b0;
    logic        alloc_is_store = 1'b0;
    logic        alloc_ready;
    logic [3:0]  alloc_tag;
    logic        cmp_valid = 1'b0;
    logic [3:0]  cmp_tag = '0;
    logic [31:0] cmp_result = '0;
    logic        cmp_fault = 1'b0;
    logic        cmp_mispredict = 1'b0;
    logic        ret_valid;
    logic [3:0]  ret_tag;
    logic [31:0] ret_result;
    logic        store_release;
    logic        exc_valid;
    logic [3:0]  exc_tag;

    rob_core i_rob_core (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_is_store(alloc_is_store),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_result(cmp_result),
        .cmp_fault(cmp_fault), .cmp_mispredict(cmp_mispredict),
        .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_result(ret_result),
        .store_release(store_release), .exc_valid(exc_valid), .exc_tag(exc_tag)
    );

    always #4 clk = ~clk;

    typedef struct {
        int          tag;
        bit          done;
        bit          fault;
        bit          st;
        logic [31:0] res;
    } ment_t;

    ment_t mq[$];
    int    head_tag = 0;
    int    next_tag = 0;
    int    checks = 0;
    int    failures = 0;
    int    nret = 0;
    int    nrel = 0;
    int    last_exc = -1;
    string scen = "R9 reset";

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h (%s)", req, what, act, exp, scen);
        end
    endtask

    // One cycle: drive inputs, compare against the model, advance the model.
    task automatic cyc(bit av, bit ast, bit cv, int ct, bit cf, bit cm);
        bit          e_exc, e_ret, e_rdy, fire, mp;
        int          hit;
        logic [31:0] res;
        res = $urandom;
        @(negedge clk);
        alloc_valid = av; alloc_is_store = ast;
        cmp_valid = cv; cmp_tag = 4'(ct); cmp_result = res;
        cmp_fault = cf; cmp_mispredict = cm;
        #1;
        e_exc = mq.size() > 0 && mq[0].done &&  mq[0].fault;
        e_ret = mq.size() > 0 && mq[0].done && !mq[0].fault;
        e_rdy = mq.size() < 16 && !e_exc;
        chk("R1", "alloc_ready", 32'(alloc_ready), 32'(e_rdy));
        chk("R1", "alloc_tag", 32'(alloc_tag), 32'(next_tag));
        chk("R2", "ret_valid", 32'(ret_valid), 32'(e_ret));
        chk("R5", "exc_valid", 32'(exc_valid), 32'(e_exc));
        chk("R7", "store_release", 32'(store_release), 32'(e_ret && mq[0].st));
        if (e_ret) begin
            chk("R2", "ret_tag", 32'(ret_tag), 32'(mq[0].tag));
            chk("R2", "ret_result", ret_result, mq[0].res);
            nret++;
            if (store_release) nrel++;
        end
        if (e_exc) begin
            chk("R5", "exc_tag", 32'(exc_tag), 32'(mq[0].tag));
            last_exc = int'(exc_tag);
            mq.delete();
            head_tag = (head_tag + 1) % 16;
            next_tag = head_tag;
        end else begin
            hit = -1;
            mp = 1'b0;
            fire = av && e_rdy;
            if (cv) foreach (mq[i]) if (mq[i].tag == ct) hit = i;
            if (hit >= 0) begin
                mq[hit].done = 1'b1;
                mq[hit].fault = cf;
                mq[hit].res = res;
                if (cm) begin
                    mp = 1'b1;
                    while (mq.size() > hit + 1) void'(mq.pop_back());
                    next_tag = (ct + 1) % 16;
                end
            end
            if (fire && !mp) begin
                mq.push_back('{next_tag, 1'b0, 1'b0, ast, 32'h0});
                next_tag = (next_tag + 1) % 16;
            end
            if (e_ret) begin
                void'(mq.pop_front());
                head_tag = (head_tag + 1) % 16;
            end
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int t0, b0, r0, s0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R9: empty after reset
        chk("R9", "alloc_ready", 32'(alloc_ready), 1);
        chk("R9", "alloc_tag", 32'(alloc_tag), 0);
        chk("R9", "ret_valid", 32'(ret_valid), 0);
        chk("R9", "exc_valid", 32'(exc_valid), 0);
        chk("R9", "store_release", 32'(store_release), 0);

        // R1: fill to 16 and try one more
        scen = "R1 fill";
        for (int i = 0; i < 17; i++) cyc(1, (i % 3) == 0, 0, 0, 0, 0);
        @(posedge clk); #1;
        chk("R1", "alloc_ready when full", 32'(alloc_ready), 0);

        // R2: complete youngest first, retirement must still be in order
        scen = "R2 reverse completion";
        r0 = nret;
        for (int i = 15; i >= 0; i--) cyc(0, 0, 1, mq[i].tag, 0, 0);
        idle(18);
        chk("R2", "retired count", r0 + 16, nret);
        chk("R7", "stores released", 32'(nrel), 6);

        // R3 and R4: younger fault first, older fault later
        scen = "R3 R4 nested faults";
        for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0, 0, 0);
        t0 = mq[0].tag;
        cyc(0, 0, 1, (t0 + 4) % 16, 1, 0);
        cyc(1, 0, 1, (t0 + 2) % 16, 1, 0);
        cyc(0, 0, 1, (t0 + 5) % 16, 0, 0);
        chk("R3", "no early exception", 32'(exc_valid), 0);
        cyc(0, 0, 1, t0, 0, 0);
        cyc(0, 0, 1, (t0 + 1) % 16, 0, 0);
        idle(5);
        chk("R4", "oldest fault wins", 32'(last_exc), 32'((t0 + 2) % 16));
        chk("R5", "tag after flush", 32'(alloc_tag), 32'((t0 + 3) % 16));
        // R8: completion of a flushed tag is ignored
        cyc(0, 0, 1, (t0 + 3) % 16, 0, 0);
        idle(2);

        // R7: faulting store never releases; clean store does
        scen = "R7 stores";
        s0 = nrel;
        cyc(1, 1, 0, 0, 0, 0);
        cyc(1, 1, 1, mq[0].tag, 1, 0);
        idle(3);
        chk("R7", "faulting store release", 32'(nrel), 32'(s0));
        cyc(1, 1, 0, 0, 0, 0);
        cyc(0, 0, 1, mq[0].tag, 0, 0);
        idle(3);
        chk("R7", "clean store release", 32'(nrel), 32'(s0 + 1));

        // R6: mispredict trims younger entries; same-cycle allocation is dropped
        scen = "R6 mispredict";
        for (int i = 0; i < 8; i++) cyc(1, 0, 0, 0, 0, 0);
        b0 = mq[0].tag;
        r0 = nret;
        cyc(1, 0, 1, (b0 + 3) % 16, 0, 1);
        @(posedge clk); #1;
        chk("R6", "tag after mispredict", 32'(alloc_tag), 32'((b0 + 4) % 16));
        scen = "R8 stray completion";
        cyc(0, 0, 1, (b0 + 5) % 16, 0, 0);
        scen = "R6 mispredict";
        cyc(0, 0, 1, (b0 + 1) % 16, 0, 0);
        cyc(0, 0, 1, b0, 0, 0);
        cyc(0, 0, 1, (b0 + 2) % 16, 0, 0);
        idle(6);
        chk("R6", "older entries retired", 32'(nret), 32'(r0 + 4));
        chk("R8", "buffer empty after drain", 32'(alloc_ready), 1);

        // Random mix of allocation, completion, faults and mispredicts
        scen = "R2 R3 R6 R8 random";
        for (int n = 0; n < 4000; n++) begin
            int tg;
            bit cv;
            cv = $urandom_range(0, 1) == 1;
            if (mq.size() > 0 && $urandom_range(0, 9) < 9)
                tg = mq[$urandom_range(0, mq.size() - 1)].tag;
            else
                tg = $urandom_range(0, 15);
            cyc($urandom_range(0, 2) != 0, $urandom_range(0, 3) == 0, cv, tg,
                $urandom_range(0, 19) == 0, $urandom_range(0, 14) == 0);
        end
        scen = "drain";
        for (int i = 0; i < 40; i++) begin
            if (mq.size() > 0) cyc(0, 0, 1, mq[0].tag, 0, 0);
            else cyc(0, 0, 0, 0, 0, 0);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule